// File: doc/BRIEF.md
# Integer Shift Unit (32/64-bit)

This block is the combinational shifter of a 64-bit integer datapath. It takes a source operand, a shift count and two selects, and returns the shifted value in the same evaluation. The count comes either from a general register or from an immediate field. A width select chooses between the narrow form and the wide form. The narrow form uses a 5-bit count, and the right shifts in it treat only the low half of the source as data.

Three shifts are provided: logical left, logical right and arithmetic right. A fourth operation code passes the source through untouched, because the block has no rotate. All three operations share one right-shifting barrel with a per-operation fill bit. A left shift reaches that barrel through a bit reversal on its input and on its output. The unit has no state and produces no flags.

Top module: `shf_unit`

## Requirements
- R1: With op_i = 2'b00 and wide_i = 1, res_o equals src_i shifted left by the 6-bit effective count, with zeros entering at bit 0.
- R2: With op_i = 2'b01 and wide_i = 1, res_o equals src_i shifted right logically by the 6-bit effective count, with zeros entering at bit 63.
- R3: With op_i = 2'b10 and wide_i = 1, res_o equals src_i shifted right by the 6-bit effective count, with copies of src_i[63] entering at the top.
- R4: With wide_i = 1, only bits [5:0] of the selected count take part, so register count bits [63:6] have no effect on res_o.
- R5: With wide_i = 0, only bits [4:0] of the selected count take part. Bit 5 of the register count or of the immediate has no effect on res_o.
- R6: With op_i = 2'b00 and wide_i = 0, the whole 64-bit src_i is shifted left by the 5-bit count.
- R7: With op_i = 2'b01 and wide_i = 0, bits [63:32] of src_i are replaced by zeros before the shift. res_o[63:32] is therefore always zero.
- R8: With op_i = 2'b10 and wide_i = 0, bits [63:32] of src_i are replaced by copies of src_i[31] before the shift. The fill comes from bit 31 and never from bit 63.
- R9: use_imm_i = 1 takes the count from cnt_imm_i. use_imm_i = 0 takes it from the low bits of cnt_reg_i.
- R10: In the wide form, an effective count of zero returns src_i unchanged for every shift operation.
- R11: op_i = 2'b11 returns src_i unchanged whatever the count and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| cnt_reg_i | input | 64 | Register holding the shift count; only its low bits are used |
| cnt_imm_i | input | 6 | Immediate shift count field |
| use_imm_i | input | 1 | 1 selects the immediate count, 0 selects the register count |
| op_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 pass |
| wide_i | input | 1 | 1 selects the 64-bit form, 0 selects the 32-bit form |
| res_o | output | 64 | Shift result |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath, a 6-bit wide count and a 5-bit narrow count. With these defaults, every stage of the barrel is reachable, including the 32-position stage, which only the wide form can enable. The bench uses sources whose bit 31 and bit 63 differ, so that a fill taken from the wrong bit becomes visible. It also sets high count bits, such as bit 5 and bits above 5, to show that they are dropped in each form.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LL   = 2'b00,
    SHF_LR   = 2'b01,
    SHF_AR   = 2'b10,
    SHF_PASS = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_count_sel.sv
module shf_count_sel #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int HCNT_W = $clog2(HALF_W)
) (
  input  logic [DATA_W-1:0] cnt_reg_i,
  input  logic [CNT_W-1:0]  cnt_imm_i,
  input  logic              use_imm_i,
  input  logic              wide_i,
  output logic [CNT_W-1:0]  eff_cnt_o
);
  logic [CNT_W-1:0] raw_cnt;

  function automatic logic [CNT_W-1:0] trim_cnt(input logic [CNT_W-1:0] c, input logic wide);
    trim_cnt = wide ? c : CNT_W'(c[HCNT_W-1:0]);
  endfunction

  always_comb begin
    raw_cnt   = use_imm_i ? cnt_imm_i : cnt_reg_i[CNT_W-1:0];
    eff_cnt_o = trim_cnt(raw_cnt, wide_i);
  end

  always_comb begin
    if (!$isunknown({wide_i, eff_cnt_o})) begin
      AST_NARROW_CNT: assert (wide_i || (int'(eff_cnt_o) < HALF_W))
        else $error("narrow count exceeds half width"); // R5
    end
  end
endmodule

// File: rtl/shf_operand_prep.sv
module shf_operand_prep
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] pre_o,
  output logic              fill_o,
  output logic              left_o,
  output logic              pass_o
);
  shf_op_e op;

  function automatic logic [DATA_W-1:0] extend_low(input logic [DATA_W-1:0] v, input logic top);
    extend_low = {{(DATA_W-HALF_W){top}}, v[HALF_W-1:0]};
  endfunction

  always_comb begin
    op     = shf_op_e'(op_i);
    left_o = (op == SHF_LL);
    pass_o = (op == SHF_PASS);
    pre_o  = src_i;
    fill_o = 1'b0;
    unique case (op)
      SHF_LR: pre_o = wide_i ? src_i : extend_low(src_i, 1'b0);
      SHF_AR: begin
        fill_o = wide_i ? src_i[DATA_W-1] : src_i[HALF_W-1];
        pre_o  = wide_i ? src_i : extend_low(src_i, src_i[HALF_W-1]);
      end
      default: pre_o = src_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({src_i, op_i, wide_i})) begin
      AST_AR_FILL_SRC: assert (!(op_i == 2'b10 && !wide_i) || fill_o == src_i[HALF_W-1])
        else $error("narrow arithmetic fill not from bit HALF_W-1"); // R8
    end
  end
endmodule

// File: rtl/shf_barrel_right.sv
module shf_barrel_right #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] stg [0:CNT_W];

  assign stg[0] = val_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = cnt_i[k] ? {{SH{fill_i}}, stg[k][DATA_W-1:SH]} : stg[k];
  end

  assign val_o = stg[CNT_W];

  always_comb begin
    if (!$isunknown({val_i, cnt_i, fill_i})) begin
      AST_ZERO_CNT_IDENT: assert (cnt_i != '0 || val_o == val_i)
        else $error("zero count changed the value"); // R10
    end
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] cnt_reg_i,
  input  logic [CNT_W-1:0]  cnt_imm_i,
  input  logic              use_imm_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o
);
  logic [CNT_W-1:0]  eff_cnt;
  logic [DATA_W-1:0] pre_val;
  logic              fill_bit;
  logic              is_left;
  logic              is_pass;
  logic [DATA_W-1:0] barrel_in;
  logic [DATA_W-1:0] barrel_out;
  logic [DATA_W-1:0] pre_rev;
  logic [DATA_W-1:0] out_rev;

  shf_count_sel #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cnt (
    .cnt_reg_i (cnt_reg_i),
    .cnt_imm_i (cnt_imm_i),
    .use_imm_i (use_imm_i),
    .wide_i    (wide_i),
    .eff_cnt_o (eff_cnt)
  );

  shf_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
    .src_i  (src_i),
    .op_i   (op_i),
    .wide_i (wide_i),
    .pre_o  (pre_val),
    .fill_o (fill_bit),
    .left_o (is_left),
    .pass_o (is_pass)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign pre_rev[b] = pre_val[DATA_W-1-b];
    assign out_rev[b] = barrel_out[DATA_W-1-b];
  end

  assign barrel_in = is_left ? pre_rev : pre_val;

  shf_barrel_right #(.DATA_W(DATA_W)) u_barrel (
    .val_i  (barrel_in),
    .cnt_i  (eff_cnt),
    .fill_i (fill_bit),
    .val_o  (barrel_out)
  );

  always_comb begin
    if (is_pass)      res_o = src_i;
    else if (is_left) res_o = out_rev;
    else              res_o = barrel_out;
  end

  always_comb begin
    if (!$isunknown({src_i, op_i, wide_i, eff_cnt, res_o})) begin
      AST_LR_NARROW_HIGH: assert (!(op_i == 2'b01 && !wide_i) || res_o[DATA_W-1:HALF_W] == '0)
        else $error("narrow logical right leaked upper bits"); // R7
      AST_AR_WIDE_SIGN: assert (!(op_i == 2'b10 && wide_i) || res_o[DATA_W-1] == src_i[DATA_W-1])
        else $error("wide arithmetic right lost sign"); // R3
      AST_LL_LSB_ZERO: assert (!(op_i == 2'b00 && eff_cnt != '0) || res_o[0] == 1'b0)
        else $error("left shift did not zero-fill bit 0"); // R1
      AST_PASS_IDENT: assert (op_i != 2'b11 || res_o == src_i)
        else $error("pass code altered source"); // R11
    end
  end
endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic [63:0] cnt_reg_i = '0;
  logic [5:0]  cnt_imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        wide_i = 1'b1;
  logic [63:0] res_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shf_unit u0 (
    .src_i(src_i), .cnt_reg_i(cnt_reg_i), .cnt_imm_i(cnt_imm_i),
    .use_imm_i(use_imm_i), .op_i(op_i), .wide_i(wide_i), .res_o(res_o)
  );

  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] cr,
      input logic [5:0] ci, input logic ui, input logic [1:0] op, input logic w);
    int n;
    logic [63:0] c;
    c = ui ? {58'd0, ci} : cr;
    n = w ? int'(c % 64) : int'(c % 32);
    case (op)
      2'b00: model = s << n;
      2'b01: model = w ? (s >> n) : ({32'd0, s[31:0]} >> n);
      2'b10: model = w ? 64'($signed(s) >>> n)
                       : 64'($signed({{32{s[31]}}, s[31:0]}) >>> n);
      default: model = s;
    endcase
  endfunction

  task automatic run(input string tag, input logic [63:0] s, input logic [63:0] cr,
      input logic [5:0] ci, input logic ui, input logic [1:0] op, input logic w);
    logic [63:0] exp;
    @(negedge clk);
    src_i = s; cnt_reg_i = cr; cnt_imm_i = ci; use_imm_i = ui; op_i = op; wide_i = w;
    #1;
    exp = model(s, cr, ci, ui, op, w);
    n_chk++;
    if (res_o !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, res_o, exp);
    end
  endtask

  task automatic t_reset();
    run("R10 reset-idle", 64'd0, 64'd0, 6'd0, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_wide_ll();
    run("R1 sll64 by 4",  64'h8123_4567_89AB_CDEF, 64'd4,  6'd0, 1'b0, 2'b00, 1'b1);
    run("R1 sll64 by 63", 64'h0000_0000_0000_0003, 64'd63, 6'd0, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_wide_lr();
    run("R2 srl64 by 36", 64'h8123_4567_89AB_CDEF, 64'd36, 6'd0, 1'b0, 2'b01, 1'b1);
    run("R2 srl64 by 1",  64'hFFFF_FFFF_FFFF_FFFF, 64'd1,  6'd0, 1'b0, 2'b01, 1'b1);
  endtask

  task automatic t_wide_ar();
    run("R3 sra64 neg by 40", 64'h8123_4567_89AB_CDEF, 64'd40, 6'd0, 1'b0, 2'b10, 1'b1);
    run("R3 sra64 pos by 63", 64'h7123_4567_89AB_CDEF, 64'd63, 6'd0, 1'b0, 2'b10, 1'b1);
  endtask

  task automatic t_wide_mask();
    run("R4 high reg bits ignored", 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC5, 6'd0, 1'b0, 2'b01, 1'b1);
  endtask

  task automatic t_narrow_mask();
    run("R5 reg bit5 ignored",  64'h8123_4567_89AB_CDEF, 64'd35, 6'd0,  1'b0, 2'b01, 1'b0);
    run("R5 imm bit5 ignored",  64'h8123_4567_89AB_CDEF, 64'd0,  6'd33, 1'b1, 2'b00, 1'b0);
  endtask

  task automatic t_narrow_ll();
    run("R6 sll32 full source", 64'hF0F0_0000_8765_4321, 64'd8, 6'd0, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_narrow_lr();
    run("R7 srl32 zero high",   64'hFFFF_FFFF_8765_4321, 64'd4, 6'd0, 1'b0, 2'b01, 1'b0);
    run("R7 srl32 by 0",        64'hFFFF_FFFF_8765_4321, 64'd0, 6'd0, 1'b0, 2'b01, 1'b0);
  endtask

  task automatic t_narrow_ar();
    run("R8 sra32 bit31 one",  64'h0000_0000_8765_4321, 64'd12, 6'd0, 1'b0, 2'b10, 1'b0);
    run("R8 sra32 bit31 zero", 64'hFFFF_FFFF_7654_3210, 64'd12, 6'd0, 1'b0, 2'b10, 1'b0);
  endtask

  task automatic t_count_src();
    run("R9 imm selected",  64'h0123_4567_89AB_CDEF, 64'd1, 6'd20, 1'b1, 2'b00, 1'b1);
    run("R9 reg selected",  64'h0123_4567_89AB_CDEF, 64'd1, 6'd20, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_zero_cnt();
    run("R10 sll64 zero", 64'h8123_4567_89AB_CDEF, 64'd64, 6'd0, 1'b0, 2'b00, 1'b1);
    run("R10 sra64 zero", 64'h8123_4567_89AB_CDEF, 64'd0,  6'd0, 1'b1, 2'b10, 1'b1);
  endtask

  task automatic t_pass();
    run("R11 pass wide",   64'h8123_4567_89AB_CDEF, 64'd17, 6'd9, 1'b0, 2'b11, 1'b1);
    run("R11 pass narrow", 64'h8123_4567_89AB_CDEF, 64'd17, 6'd9, 1'b1, 2'b11, 1'b0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide_ll();
    t_wide_lr();
    t_wide_ar();
    t_wide_mask();
    t_narrow_mask();
    t_narrow_ll();
    t_narrow_lr();
    t_narrow_ar();
    t_count_src();
    t_zero_cnt();
    t_pass();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule